// File: doc/BRIEF.md
# Clock Enable Divider and Gating Unit

This block produces every clock enable of the chip from a single fast reference domain. There are three clock groups: CPU, main bus and special peripheral. Each group takes its tick stream either from a shared bypass reference tick or from its own PLL-derived tick. The output is a set of single-cycle enable strobes, one for each clock, and the clocked logic downstream uses them as clock enables. No real clock nets are switched.

The CPU group divides its source by a programmable ratio from 1 to 16. The main-bus group is a chain of dividers. The source is first divided into a double-rate memory enable. That enable is divided by 1 or 2 to give the AHB enable, and separately by a 4-bit ratio to give the APB enable. Each enable class has its own gate mask, and each mask bit switches one consumer's enable on or off. Two mask bits serve the memory ports on the double-rate enable. A combinational flag reports a divider setting whose AHB-to-APB ratio is not even.

A new divider value is taken up only when the divider produces its next pulse. A period that has already started therefore never gets shorter or longer.

Top module: `ckg_top`

## Requirements
- R1: `src_sel_i` holds one bit per group: bit 0 is the CPU group, bit 1 the main bus and bit 2 the special group. A bit at 0 makes `ref_tick_i` the group's tick. A bit at 1 makes `pll_tick_i[g]` the tick of group g.
- R2: The CPU field `div_cfg_i[3:0]`, with value N, makes `cpu_en_o` pulse on every (N+1)-th CPU source tick. This covers ratios 1 to 16.
- R3: While `rst_ni` is low and no tick is present, every enable output is 0. After reset, the first source tick of a group pulses every divider output of that group in the same cycle, so a chain starts in phase.
- R4: The memory field `div_cfg_i[7:4]`, with value M, makes `mem2x_en_o` pulse on every (M+1)-th bus source tick.
- R5: `hclk_en_o` pulses on every `mem2x_en_o` pulse when `div_cfg_i[8]` is 0, and on every second one when it is 1.
- R6: The APB field `div_cfg_i[15:12]`, with value P, makes `pclk_en_o` pulse on every (P+1)-th `mem2x_en_o` pulse.
- R7: `cfg_err_o` is 1 exactly when `div_cfg_i[8]` is 1 and `div_cfg_i[12]` is 0, that is, when the APB field is even while the AHB ratio is 2. It is combinational.
- R8: With a legal setting held since reset, every `pclk_en_o` pulse coincides with an `hclk_en_o` pulse.
- R9: A change to a divider field takes effect only after that divider's next pulse. The period in progress completes at the old ratio.
- R10: `hgate_i[1:0]` gates `mem_port_en_o[1:0]` from `mem2x_en_o`. `hgate_i[NUM_AHB+1:2]` gates `ahb_per_en_o` from `hclk_en_o`. `pgate_i` gates `apb_per_en_o` from `pclk_en_o`. `sgate_i` gates `spc_per_en_o` from the special group's source tick. A cleared bit holds its output at 0.
- R11: Every enable is combinational in the cycle of the source tick that causes it. It is 1 only in cycles where the group's selected tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast reference clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ref_tick_i | input | 1 | bypass reference tick |
| pll_tick_i | input | 3 | PLL-derived tick for each group |
| src_sel_i | input | 3 | source select for each group |
| div_cfg_i | input | 16 | divider register |
| hgate_i | input | NUM_AHB+2 | gate mask for the memory ports and AHB consumers |
| pgate_i | input | NUM_APB | gate mask for APB consumers |
| sgate_i | input | NUM_SPC | gate mask for special consumers |
| cpu_en_o | output | 1 | CPU clock enable |
| mem2x_en_o | output | 1 | double-rate memory enable |
| hclk_en_o | output | 1 | AHB enable |
| pclk_en_o | output | 1 | APB enable |
| cfg_err_o | output | 1 | illegal AHB/APB ratio flag |
| mem_port_en_o | output | 2 | gated enables for the memory ports |
| ahb_per_en_o | output | NUM_AHB | gated AHB consumer enables |
| apb_per_en_o | output | NUM_APB | gated APB consumer enables |
| spc_per_en_o | output | NUM_SPC | gated special consumer enables |

## Verification
The sweep covers all eight source selections, all sixteen APB and CPU ratios, both AHB ratios and three memory ratios. The reference tick and the three PLL ticks each follow a different periodic pattern, so a wrongly selected source shifts the pulse positions. Gate masks change every cycle, which separates masking from division. A directed run changes the CPU ratio in the middle of a period to tell deferred reload apart from immediate reload. Legal and illegal pairs of AHB and APB ratios exercise the error flag and the in-phase rule of the chain.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int CFG_W    = 16;
  localparam int DIV_W    = 4;
  localparam int CPU_LSB  = 0;
  localparam int MEM_LSB  = 4;
  localparam int HDIV_BIT = 8;
  localparam int PDIV_LSB = 12;
  localparam int N_GRP    = 3;
  localparam int GRP_CPU  = 0;
  localparam int GRP_BUS  = 1;
  localparam int GRP_SPC  = 2;
  localparam int MEM_PORTS = 2;
endpackage

// File: rtl/ckg_div.sv
module ckg_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q, lim_q;
  logic         term;

  assign term    = (cnt_q == lim_q);
  assign pulse_o = tick_i & term;

  // new ratio is loaded only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        lim_q <= ratio_i;
      end else begin
        cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
      end
    end
  end
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate #(
  parameter int W = 4
) (
  input  logic         en_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] en_o
);
  assign en_o = {W{en_i}} & mask_i;
endmodule

// File: rtl/ckg_top.sv
module ckg_top
  import ckg_pkg::*;
#(
  parameter int NUM_AHB = 4,
  parameter int NUM_APB = 4,
  parameter int NUM_SPC = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ref_tick_i,
  input  logic [N_GRP-1:0]         pll_tick_i,
  input  logic [N_GRP-1:0]         src_sel_i,
  input  logic [CFG_W-1:0]         div_cfg_i,
  input  logic [NUM_AHB+MEM_PORTS-1:0] hgate_i,
  input  logic [NUM_APB-1:0]       pgate_i,
  input  logic [NUM_SPC-1:0]       sgate_i,
  output logic                     cpu_en_o,
  output logic                     mem2x_en_o,
  output logic                     hclk_en_o,
  output logic                     pclk_en_o,
  output logic                     cfg_err_o,
  output logic [MEM_PORTS-1:0]     mem_port_en_o,
  output logic [NUM_AHB-1:0]       ahb_per_en_o,
  output logic [NUM_APB-1:0]       apb_per_en_o,
  output logic [NUM_SPC-1:0]       spc_per_en_o
);
  localparam int HG_W = NUM_AHB + MEM_PORTS;

  logic [N_GRP-1:0] grp_tick;

  for (genvar g = 0; g < N_GRP; g++) begin : g_src
    assign grp_tick[g] = src_sel_i[g] ? pll_tick_i[g] : ref_tick_i;
  end

  logic [DIV_W-1:0] cpu_ratio, mem_ratio, apb_ratio;
  logic             ahb_ratio;

  assign cpu_ratio = div_cfg_i[CPU_LSB +: DIV_W];
  assign mem_ratio = div_cfg_i[MEM_LSB +: DIV_W];
  assign ahb_ratio = div_cfg_i[HDIV_BIT];
  assign apb_ratio = div_cfg_i[PDIV_LSB +: DIV_W];

  ckg_div #(.W(DIV_W)) u_cpu_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(grp_tick[GRP_CPU]),
    .ratio_i(cpu_ratio), .pulse_o(cpu_en_o));

  ckg_div #(.W(DIV_W)) u_mem_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(grp_tick[GRP_BUS]),
    .ratio_i(mem_ratio), .pulse_o(mem2x_en_o));

  // AHB and APB both count memory pulses so they start in phase
  ckg_div #(.W(1)) u_ahb_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(mem2x_en_o),
    .ratio_i(ahb_ratio), .pulse_o(hclk_en_o));

  ckg_div #(.W(DIV_W)) u_apb_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(mem2x_en_o),
    .ratio_i(apb_ratio), .pulse_o(pclk_en_o));

  // AHB/APB ratio must be even: APB field odd when AHB divides by 2
  assign cfg_err_o = ahb_ratio & ~apb_ratio[0];

  ckg_gate #(.W(MEM_PORTS)) u_mem_gate (
    .en_i(mem2x_en_o), .mask_i(hgate_i[MEM_PORTS-1:0]), .en_o(mem_port_en_o));

  ckg_gate #(.W(NUM_AHB)) u_ahb_gate (
    .en_i(hclk_en_o), .mask_i(hgate_i[HG_W-1:MEM_PORTS]), .en_o(ahb_per_en_o));

  ckg_gate #(.W(NUM_APB)) u_apb_gate (
    .en_i(pclk_en_o), .mask_i(pgate_i), .en_o(apb_per_en_o));

  ckg_gate #(.W(NUM_SPC)) u_spc_gate (
    .en_i(grp_tick[GRP_SPC]), .mask_i(sgate_i), .en_o(spc_per_en_o));
endmodule

// File: rtl/ckg_chk.sv
module ckg_chk #(
  parameter int NUM_AHB = 4,
  parameter int NUM_APB = 4,
  parameter int NUM_SPC = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ref_tick_i,
  input logic [2:0]           pll_tick_i,
  input logic [15:0]          div_cfg_i,
  input logic                 cpu_en_o,
  input logic                 mem2x_en_o,
  input logic                 hclk_en_o,
  input logic                 pclk_en_o,
  input logic                 cfg_err_o,
  input logic [1:0]           mem_port_en_o,
  input logic [NUM_AHB-1:0]   ahb_per_en_o,
  input logic [NUM_APB-1:0]   apb_per_en_o
);
  logic        ok_q, seen_q;
  logic [15:0] prev_q;
  logic        steady;

  assign steady = ok_q && !cfg_err_o && (!seen_q || div_cfg_i == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b1;
      seen_q <= 1'b0;
      prev_q <= '0;
    end else begin
      seen_q <= 1'b1;
      prev_q <= div_cfg_i;
      if (!steady) ok_q <= 1'b0;
    end
  end

  a_r8_apb_with_ahb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && pclk_en_o) |-> hclk_en_o);

  a_r5_ahb_from_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_en_o |-> mem2x_en_o);

  a_r11_cpu_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> (ref_tick_i || pll_tick_i[0]));

  a_r10_mem_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_port_en_o) |-> mem2x_en_o);

  a_r10_ahb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ahb_per_en_o) |-> hclk_en_o);

  a_r10_apb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|apb_per_en_o) |-> pclk_en_o);
endmodule

bind ckg_top ckg_chk #(.NUM_AHB(NUM_AHB), .NUM_APB(NUM_APB), .NUM_SPC(NUM_SPC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .pll_tick_i(pll_tick_i),
  .div_cfg_i(div_cfg_i), .cpu_en_o(cpu_en_o), .mem2x_en_o(mem2x_en_o),
  .hclk_en_o(hclk_en_o), .pclk_en_o(pclk_en_o), .cfg_err_o(cfg_err_o),
  .mem_port_en_o(mem_port_en_o), .ahb_per_en_o(ahb_per_en_o),
  .apb_per_en_o(apb_per_en_o));

// File: tb/sim_ckg_top.sv
module sim_ckg_top;
  localparam int CLK_P = 10;
  localparam int NA = 4, NP = 4, NS = 3;

  logic clk = 1'b0, rst_ni = 1'b0, ref_tick = 1'b0;
  logic [2:0] pll_tick = '0, src_sel = '0;
  logic [15:0] div_cfg = '0;
  logic [NA+1:0] hgate = '0;
  logic [NP-1:0] pgate = '0;
  logic [NS-1:0] sgate = '0;
  logic cpu_en, mem2x_en, hclk_en, pclk_en, cfg_err;
  logic [1:0] mem_port_en;
  logic [NA-1:0] ahb_per_en;
  logic [NP-1:0] apb_per_en;
  logic [NS-1:0] spc_per_en;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ckg_top #(.NUM_AHB(NA), .NUM_APB(NP), .NUM_SPC(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
    .src_sel_i(src_sel), .div_cfg_i(div_cfg), .hgate_i(hgate), .pgate_i(pgate),
    .sgate_i(sgate), .cpu_en_o(cpu_en), .mem2x_en_o(mem2x_en), .hclk_en_o(hclk_en),
    .pclk_en_o(pclk_en), .cfg_err_o(cfg_err), .mem_port_en_o(mem_port_en),
    .ahb_per_en_o(ahb_per_en), .apb_per_en_o(apb_per_en), .spc_per_en_o(spc_per_en));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_ticks(input int c);
    ref_tick = (c % 3) != 2;
    pll_tick[0] = c[0];
    pll_tick[1] = (c % 4) != 3;
    pll_tick[2] = c[1];
  endtask

  task automatic do_reset(input logic [2:0] sel, input logic [15:0] cfg);
    @(negedge clk);
    rst_ni = 1'b0; ref_tick = 0; pll_tick = '0;
    src_sel = sel; div_cfg = cfg;
    @(negedge clk);
    #1;
    chk("R3 reset cpu", cpu_en, 0);
    chk("R3 reset mem2x", mem2x_en, 0);
    chk("R3 reset pclk", {hclk_en, pclk_en}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_cfg(input logic [2:0] sel, input int cn, input int m,
                         input int b, input int p, input int ncyc);
    int ck = 0, bk = 0;
    logic tc, tb, ts, em, eh, ep;
    int j;
    logic [15:0] cfg;
    cfg = 16'(cn) | 16'(m << 4) | 16'(b << 8) | 16'(p << 12);
    do_reset(sel, cfg);
    chk("R7 err flag", cfg_err, (b == 1 && (p % 2) == 0) ? 1 : 0);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      set_ticks(c);
      hgate = 6'(c * 5 + 1);
      pgate = 4'(c * 3 + 2);
      sgate = 3'(c + 3);
      #1;
      tc = sel[0] ? pll_tick[0] : ref_tick;
      tb = sel[1] ? pll_tick[1] : ref_tick;
      ts = sel[2] ? pll_tick[2] : ref_tick;
      em = tb && (bk % (m + 1) == 0);
      j  = bk / (m + 1);
      eh = em && (j % (b + 1) == 0);
      ep = em && (j % (p + 1) == 0);
      chk("R2 R1 cpu_en", cpu_en, (tc && (ck % (cn + 1) == 0)) ? 1 : 0);
      chk("R4 R1 mem2x_en", mem2x_en, em);
      chk("R5 hclk_en", hclk_en, eh);
      chk("R6 pclk_en", pclk_en, ep);
      if (!cfg_err && pclk_en) chk("R8 apb in ahb", hclk_en, 1);
      chk("R10 mem gate", mem_port_en, em ? hgate[1:0] : 0);
      chk("R10 ahb gate", ahb_per_en, eh ? hgate[5:2] : 0);
      chk("R10 apb gate", apb_per_en, ep ? pgate : 0);
      chk("R10 R1 spc gate", spc_per_en, ts ? sgate : 0);
      if (tc) ck++;
      if (tb) bk++;
    end
  endtask

  task automatic run_defer();
    do_reset(3'b000, 16'h0003);
    pll_tick = '0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      if (c == 6) div_cfg = 16'h0001;
      #1;
      chk("R9 deferred reload", cpu_en,
          (c == 0 || c == 4 || c == 8 || c == 10 || c == 12) ? 1 : 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 16; p++)
        for (int b = 0; b < 2; b++)
          run_cfg(3'(s), p, (p + s) % 3, b, p, 80);
    run_defer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule